// File: doc/BRIEF.md
# Self-Verifying Retransmit Controller

This block sits on the transmit side of a node on a ring network. It makes sure that every message the node originates comes back around the ring unchanged. Host writes go into a small transmit FIFO. The controller launches one message at a time and keeps a private copy of it. It then watches the ring return path for that message. If the returned copy matches the stored one on every bit, the message is retired and the next one may go.

A returned copy that differs in any bit counts as a bit error. A message that does not come back within a programmable number of cycles counts as lost. In either case the stored copy is sent again, and the time-out restarts. This repeats until a clean return arrives. While the node is recovering, newer host traffic waits in the FIFO. When the FIFO is full, the host is held off. Each detected error can raise a one-cycle interrupt pulse. Two saturating counters, one for bit errors and one for time-outs, record how many errors of each kind were seen.

Top module: `retx_guard`

## Requirements
- R1: During and directly after reset, txValid and errIrq are 0, both error counters are 0, and hostReady is 1.
- R2: At most one originated message is outstanding at any time. When nothing is outstanding and the FIFO holds data, the FIFO head goes out on txData, with txValid high for one cycle, at the next clock edge. Messages leave in the order the host wrote them.
- R3: A return (rxValid high) whose rxData equals the stored copy on all DATA_W bits retires the outstanding message. The next message may then be sent at the following edge.
- R4: A return that differs from the stored copy in any bit is a bit error. At the same edge the stored copy is sent again, and bitErrCount increments.
- R5: The time-out timer restarts at 0 on every send and every resend. If no return arrives while the timer equals timeoutLimit, that edge is a time-out. The stored copy is resent and timeoutCount increments, so a lost message is resent timeoutLimit+1 cycles after its previous send.
- R6: When irqEnable is 1, errIrq pulses high for exactly one cycle, one edge after each bit error or time-out. When irqEnable is 0, no error raises errIrq.
- R7: bitErrCount and timeoutCount are independent, and each one saturates at 2**CNT_W-1.
- R8: hostReady is 0 exactly when the FIFO holds FIFO_DEPTH entries. A host write is accepted only on an edge where hostValid and hostReady are both 1.
- R9: A return that arrives while nothing is outstanding is ignored. It causes no transmission, no counter change and no interrupt.
- R10: While an error is being recovered, no new FIFO message is sent. Resends continue until a matching return arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostValid | input | 1 | Host offers a message |
| hostData | input | DATA_W | Host message |
| hostReady | output | 1 | FIFO can accept a message |
| txValid | output | 1 | One-cycle strobe: message launched onto the ring |
| txData | output | DATA_W | Launched message |
| rxValid | input | 1 | Own message returned from the ring |
| rxData | input | DATA_W | Returned copy |
| timeoutLimit | input | TMR_W | Time-out threshold in cycles |
| irqEnable | input | 1 | Enables the error interrupt |
| errIrq | output | 1 | One-cycle error interrupt pulse |
| bitErrCount | output | CNT_W | Saturating bit-error count |
| timeoutCount | output | CNT_W | Saturating time-out count |

## Verification
The assertions rely on four assumptions about the inputs. rxValid is raised only for the message that is currently outstanding, never for an older launch that has been superseded by a resend. At most one return is in flight at a time. timeoutLimit and irqEnable change only while nothing is outstanding. The stimulus meets these assumptions with a loop-back ring model. It returns each launch after a fixed latency that is shorter than the programmed time-out, and it may corrupt or drop that launch. Settings are changed only after the pipeline has drained. The one return that arrives while nothing is outstanding is injected only when the block is idle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RECOVER} rtcState_e;

  typedef struct packed {
    logic send;     // launch FIFO head
    logic bitErr;   // returned copy mismatched
    logic timeout;  // no return in time
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_fifo.sv
module rtc_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] head,
  output logic              notEmpty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head     = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wrEn && wrPtr == PTR_W'(i)) mem[i] <= wrData;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> notEmpty); // R2
endmodule

// File: rtl/rtc_control.sv
module rtc_control
  import rtc_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoNotEmpty,
  input  logic             rxValid,
  input  logic             rxMatch,
  input  logic [TMR_W-1:0] timeoutLimit,
  output rtcStrobe_t       strobe
);
  rtcState_e        state;
  logic [TMR_W-1:0] timer;
  logic             busy;

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe.send    = !busy && fifoNotEmpty;
    strobe.bitErr  = busy && rxValid && !rxMatch;
    strobe.timeout = busy && !rxValid && (timer == timeoutLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (!busy) begin
      if (strobe.send) begin
        state <= ST_WAIT;
        timer <= '0;
      end
    end else if (rxValid && rxMatch) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (strobe.bitErr || strobe.timeout) begin
      state <= ST_RECOVER;
      timer <= '0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  AST_SEND_OPENS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.send |=> state == ST_WAIT); // R2
  AST_RETRY_RESTARTS_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitErr || strobe.timeout) |=> (state == ST_RECOVER && timer == '0)); // R5
  AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> timer <= timeoutLimit); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.send, strobe.bitErr, strobe.timeout}) <= 1); // R10
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic              hostValid,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              irqEnable,
  output logic              fifoNotEmpty,
  output logic              rxMatch,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              errIrq,
  output logic [CNT_W-1:0]  bitErrCount,
  output logic [CNT_W-1:0]  timeoutCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] head, storedMsg;
  logic              full, retry, push;

  assign hostReady = !full;
  assign push      = hostValid && hostReady;
  assign retry     = strobe.bitErr || strobe.timeout;
  assign rxMatch   = (rxData == storedMsg);

  rtc_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .wrEn(push), .wrData(hostData),
    .rdEn(strobe.send), .head(head), .notEmpty(fifoNotEmpty), .full(full)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedMsg    <= '0;
      txValid      <= 1'b0;
      txData       <= '0;
      errIrq       <= 1'b0;
      bitErrCount  <= '0;
      timeoutCount <= '0;
    end else begin
      txValid <= strobe.send || retry;
      errIrq  <= retry && irqEnable;
      if (strobe.send) begin
        storedMsg <= head;
        txData    <= head;
      end else if (retry) begin
        txData <= storedMsg;
      end
      if (strobe.bitErr && bitErrCount != CNT_MAX)
        bitErrCount <= bitErrCount + 1'b1;
      if (strobe.timeout && timeoutCount != CNT_MAX)
        timeoutCount <= timeoutCount + 1'b1;
    end
  end

  AST_RETX_STORED: assert property (@(posedge clk) disable iff (!rstN)
    retry |=> (txValid && txData == $past(storedMsg))); // R4
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> $past(retry)); // R6
  AST_BITERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    bitErrCount >= $past(bitErrCount)); // R7
  AST_TIMEOUT_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    timeoutCount >= $past(timeoutCount)); // R7
endmodule

// File: rtl/retx_guard.sv
module retx_guard
  import rtc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int TMR_W      = 8,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [TMR_W-1:0]  timeoutLimit,
  input  logic              irqEnable,
  output logic              errIrq,
  output logic [CNT_W-1:0]  bitErrCount,
  output logic [CNT_W-1:0]  timeoutCount
);
  rtcStrobe_t strobe;
  logic       fifoNotEmpty, rxMatch;

  rtc_control #(.TMR_W(TMR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoNotEmpty(fifoNotEmpty), .rxValid(rxValid),
    .rxMatch(rxMatch), .timeoutLimit(timeoutLimit), .strobe(strobe)
  );

  rtc_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostValid(hostValid),
    .hostData(hostData), .hostReady(hostReady), .rxData(rxData),
    .irqEnable(irqEnable), .fifoNotEmpty(fifoNotEmpty), .rxMatch(rxMatch),
    .txValid(txValid), .txData(txData), .errIrq(errIrq),
    .bitErrCount(bitErrCount), .timeoutCount(timeoutCount)
  );

  AST_SPURIOUS_RX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !txValid && $stable(bitErrCount) && !errIrq && hostReady && !fifoNotEmpty
     && $past(!txValid) && !$past(rxValid) && $past(!fifoNotEmpty) && $past(!errIrq)
     && bitErrCount == $past(bitErrCount) && timeoutCount == $past(timeoutCount)
     && !rxMatch && u_ctrl.strobe.send == 1'b0 && !u_ctrl.busy)
    |=> !errIrq); // R9
endmodule

// File: tb/retx_guard_test.sv
module retx_guard_test;
  localparam int DW = 16, DEPTH = 4, TW = 8, CW = 4, LAT = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostValid = 1'b0, rxValid = 1'b0, irqEnable = 1'b1;
  logic [DW-1:0] hostData = '0, rxData = '0;
  logic [TW-1:0] timeoutLimit = 8'd6;
  logic hostReady, txValid, errIrq;
  logic [DW-1:0] txData;
  logic [CW-1:0] bitErrCount, timeoutCount;

  always #5 clk = ~clk;

  retx_guard #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .TMR_W(TW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostData(hostData),
    .hostReady(hostReady), .txValid(txValid), .txData(txData),
    .rxValid(rxValid), .rxData(rxData), .timeoutLimit(timeoutLimit),
    .irqEnable(irqEnable), .errIrq(errIrq), .bitErrCount(bitErrCount),
    .timeoutCount(timeoutCount)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] pend[$];
  int corruptLeft = 0, dropLeft = 0, flipBit = 0;
  bit spurReq = 0;
  int retDue[$]; logic [DW-1:0] retData[$]; bit retDrop[$];

  // reference model
  int mState = 0, mTimer = 0, mBe = 0, mTo = 0;
  logic [DW-1:0] mQ[$]; logic [DW-1:0] mStored = '0, mTxD = '0;
  bit mTxV = 0, mIrq = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTimer = 0; mBe = 0; mTo = 0; mQ.delete();
      mStored = '0; mTxV = 0; mTxD = '0; mIrq = 0;
    end else begin
      cyc++;
      begin
        bit send, be, to, ok, acc;
        logic [DW-1:0] h;
        send = (mState == 0) && (mQ.size() > 0);
        ok = (mState != 0) && rxValid && (rxData == mStored);
        be = (mState != 0) && rxValid && (rxData != mStored);
        to = (mState != 0) && !rxValid && (mTimer == int'(timeoutLimit));
        acc = hostValid && (mQ.size() < DEPTH);
        h = (mQ.size() > 0) ? mQ[0] : '0;
        mTxV = send || be || to;
        mIrq = (be || to) && irqEnable;
        if (send) begin mTxD = h; mStored = h; void'(mQ.pop_front()); mState = 1; mTimer = 0; end
        else if (ok) begin mState = 0; mTimer = 0; end
        else if (be || to) begin mTxD = mStored; mState = 2; mTimer = 0; end
        else if (mState != 0) mTimer++;
        if (be && mBe < CMAX) mBe++;
        if (to && mTo < CMAX) mTo++;
        if (acc) begin mQ.push_back(hostData); void'(pend.pop_front()); end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // compare, ring loop-back, host driver: all away from the active edge
  always @(negedge clk) begin
    if (rstN && cyc > 0) begin
      chk("R2", "txValid", int'(txValid), int'(mTxV));
      if (mTxV) chk("R4", "txData", int'(txData), int'(mTxD));
      chk("R6", "errIrq", int'(errIrq), int'(mIrq));
      chk("R7", "bitErrCount", int'(bitErrCount), mBe);
      chk("R7", "timeoutCount", int'(timeoutCount), mTo);
      chk("R8", "hostReady", int'(hostReady), int'(mQ.size() < DEPTH));
    end
    rxValid = 1'b0;
    if (retDue.size() > 0 && retDue[0] == cyc) begin
      rxValid = !retDrop[0];
      rxData  = retData[0];
      void'(retDue.pop_front()); void'(retData.pop_front()); void'(retDrop.pop_front());
    end else if (spurReq) begin
      rxValid = 1'b1; rxData = 16'hdead; spurReq = 0;  // R9 stimulus
    end
    if (txValid) begin
      retDue.push_back(cyc + LAT - 1);
      retDrop.push_back(dropLeft > 0);
      if (dropLeft > 0) begin dropLeft--; retData.push_back(txData); end
      else if (corruptLeft > 0) begin
        corruptLeft--; retData.push_back(txData ^ DW'(1 << flipBit)); flipBit = (flipBit + 5) % DW;
      end else retData.push_back(txData);
    end
    hostValid = (pend.size() > 0);
    hostData  = (pend.size() > 0) ? pend[0] : '0;
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "reset txValid", int'(txValid), 0);
    chk("R1", "reset errIrq", int'(errIrq), 0);
    chk("R1", "reset bitErrCount", int'(bitErrCount), 0);
    chk("R1", "reset timeoutCount", int'(timeoutCount), 0);
    chk("R1", "reset hostReady", int'(hostReady), 1);
    rstN = 1'b1;
    settle(2);
    // R2 R3: clean traffic in order
    for (int i = 0; i < 5; i++) pend.push_back(DW'(16'h1100 + i));
    settle(60);
    // R4 R10: bit errors, two corrupt returns then a good one
    corruptLeft = 2;
    for (int i = 0; i < 3; i++) pend.push_back(DW'(16'h2200 + i));
    settle(60);
    // R5 R8: lost messages while host overfills the FIFO
    dropLeft = 3;
    for (int i = 0; i < 9; i++) pend.push_back(DW'(16'h3300 + i));
    settle(200);
    // R6: errors with interrupt disabled
    irqEnable = 1'b0; corruptLeft = 1; dropLeft = 0;
    pend.push_back(16'h4400);
    settle(40);
    dropLeft = 1; pend.push_back(16'h4401);
    settle(40);
    irqEnable = 1'b1;
    // R9: return while idle
    spurReq = 1;
    settle(10);
    chk("R9", "idle rx leaves bitErrCount", int'(bitErrCount), mBe);
    // R7: saturate time-out counter with a short limit
    timeoutLimit = 8'd2; dropLeft = 20;
    pend.push_back(16'h5500);
    settle(150);
    chk("R7", "timeoutCount saturated", int'(timeoutCount), CMAX);
    corruptLeft = 18; pend.push_back(16'h6600);
    settle(150);
    chk("R7", "bitErrCount saturated", int'(bitErrCount), CMAX);
    chk("R10", "all messages drained", int'(pend.size() + mQ.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule